// File: doc/BRIEF.md
# Address-Strobed Control Bit Register

This block holds eight control lines for a small 8-bit processor system and changes them without using the data bus. Each control line is set or cleared by a bus access to one address in a 16-byte window. The address alone carries the command. The low address bit gives the new level. The next three address bits pick which control line takes that level. A plain load from the right address can therefore raise or drop a line such as a memory bank select. Load and store accesses behave the same way, because no read/write strobe or data value takes part.

The bus is sampled on a fast system clock. The phase-2 bus clock and the address are treated as signals synchronous to that clock. An access counts only while phase 2 is high. The change is committed once, in the clock cycle in which phase 2 is first seen low again, using the address that was present in the last phase-2-high cycle. The active-low system reset clears every line at once, with no clock needed. Its release is synchronised to the system clock. A bus phase that was already open when reset was released is discarded.

Top module: `softsw_reg`

## Requirements
- R1: The block responds only when address bits 15..4 equal bits 15..4 of the base parameter (default 0xC080, so the window is 0xC080..0xC08F). Any other address leaves all outputs unchanged.
- R2: Outputs never change while phase 2 is high. A selected access takes effect at the first rising system-clock edge that samples phase 2 low after it was high.
- R3: Address bit 0 is the new level of the addressed output: 1 sets it and 0 clears it.
- R4: Address bits 3..1 form the output index, with bit 1 as the least significant bit. Address 0xC08F, for example, sets output 7.
- R5: A committed access changes at most the one addressed output. All other outputs keep their values.
- R6: Driving the reset input low forces all eight outputs to 0 at once, without waiting for a clock edge, and they stay 0 while reset is held.
- R7: Accesses made while reset is held are ignored. This includes a phase-2 pulse that began during reset and ends after reset is released.
- R8: Only the address sampled in the last system-clock cycle with phase 2 high decides the update. A different address earlier in the same phase has no effect.
- R9: A phase-2 high time spanning any number of system clocks produces exactly one update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; phase 2 and address are sampled on its rising edge |
| rstN | input | 1 | Active-low system reset: asserts asynchronously, releases synchronously |
| phi2 | input | 1 | Bus phase-2 clock level; an access is qualified while it is high |
| addr | input | 16 | Processor address bus |
| ctrlBits | output | 8 | Control outputs |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a base of 0xC080 and a two-stage reset synchroniser. With these values, the in-window addresses in the vector table reach every output index and both levels. The out-of-window addresses differ from the base either just below or just above it, or only in address bit 15. With the two-stage release, the bench can also hold a phase-2 pulse open across the end of reset.

// File: rtl/softsw_pkg.sv
package softsw_pkg;
  localparam int SW_BITS  = 8;
  localparam int SW_IDX_W = $clog2(SW_BITS);

  typedef enum logic [1:0] {
    ST_WAIT_LOW = 2'd0,
    ST_IDLE     = 2'd1,
    ST_ACTIVE   = 2'd2
  } busPhase_e;

  typedef struct packed {
    logic                commit;
    logic                setVal;
    logic [SW_IDX_W-1:0] bitIdx;
  } bitCmd_t;
endpackage

// File: rtl/softsw_decode.sv
module softsw_decode
  import softsw_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC080
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [SW_IDX_W-1:0] bitIdx,
  output logic                setVal
);
  // The low bits of the window carry the value bit and the index.
  localparam int LOW_W = SW_IDX_W + 1;

  always_comb begin
    hit    = (addr[ADDR_W-1:LOW_W] == BASE_ADDR[ADDR_W-1:LOW_W]);
    bitIdx = addr[LOW_W-1:1];
    setVal = addr[0];
  end
endmodule

// File: rtl/softsw_ctrl.sv
module softsw_ctrl
  import softsw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                phi2,
  input  logic                hit,
  input  logic [SW_IDX_W-1:0] bitIdx,
  input  logic                setVal,
  output bitCmd_t             cmd
);
  busPhase_e           state;
  logic                heldHit;
  logic                heldVal;
  logic [SW_IDX_W-1:0] heldIdx;

  // The last phase-2-high sample of the address wins. The commit
  // fires once, in the first cycle that sees phase 2 low again.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT_LOW;
      heldHit <= 1'b0;
      heldVal <= 1'b0;
      heldIdx <= '0;
    end else begin
      unique case (state)
        ST_WAIT_LOW: if (!phi2) state <= ST_IDLE;
        ST_IDLE: begin
          if (phi2) begin
            state   <= ST_ACTIVE;
            heldHit <= hit;
            heldVal <= setVal;
            heldIdx <= bitIdx;
          end
        end
        ST_ACTIVE: begin
          if (phi2) begin
            heldHit <= hit;
            heldVal <= setVal;
            heldIdx <= bitIdx;
          end else begin
            state   <= ST_IDLE;
            heldHit <= 1'b0;
          end
        end
        default: state <= ST_WAIT_LOW;
      endcase
    end
  end

  always_comb begin
    cmd.commit = (state == ST_ACTIVE) && !phi2 && heldHit;
    cmd.setVal = heldVal;
    cmd.bitIdx = heldIdx;
  end

  // R9: a commit is never followed directly by another one
  a_r9_one_per_phase: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> !cmd.commit);

  // R2: a commit only happens right after phase 2 has fallen
  a_r2_commit_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> ($past(phi2) && !phi2));
endmodule

// File: rtl/softsw_bits.sv
module softsw_bits
  import softsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bitCmd_t            cmd,
  output logic [SW_BITS-1:0] bits
);
  for (genvar i = 0; i < SW_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bits[i] <= 1'b0;
      else if (cmd.commit && (cmd.bitIdx == SW_IDX_W'(i)))
        bits[i] <= cmd.setVal;
    end
  end

  // R5: no more than one output changes per edge
  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(bits ^ $past(bits)) <= 1));

  // R2: without a commit, the outputs hold
  a_r2_hold_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.commit |=> $stable(bits));

  // R3: the addressed output takes the commanded level
  a_r3_level: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (bits[$past(cmd.bitIdx)] == $past(cmd.setVal)));
endmodule

// File: rtl/softsw_reg.sv
module softsw_reg
  import softsw_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'hC080,
  parameter int                RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phi2,
  input  logic [ADDR_W-1:0]  addr,
  output logic [SW_BITS-1:0] ctrlBits
);
  logic [RST_STAGES-1:0] rstPipe;
  logic                  rstSyncN;
  logic                  hit;
  logic                  setVal;
  logic [SW_IDX_W-1:0]   bitIdx;
  bitCmd_t               cmd;

  // The reset asserts at once and is released through a flop chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[RST_STAGES-2:0], 1'b1};
  end
  assign rstSyncN = rstPipe[RST_STAGES-1];

  softsw_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uDecode (
    .addr(addr), .hit(hit), .bitIdx(bitIdx), .setVal(setVal));

  softsw_ctrl uCtrl (
    .clk(clk), .rstN(rstSyncN), .phi2(phi2), .hit(hit),
    .bitIdx(bitIdx), .setVal(setVal), .cmd(cmd));

  softsw_bits uBits (
    .clk(clk), .rstN(rstSyncN), .cmd(cmd), .bits(ctrlBits));

  // R6: while reset is held, every output reads 0
  a_r6_reset_clear: assert property (@(posedge clk)
    !rstN |-> (ctrlBits == '0));

  // R7: in the first cycle after release, the outputs are still clear
  a_r7_release_clean: assert property (@(posedge clk) disable iff (!rstSyncN)
    $rose(rstSyncN) |-> (ctrlBits == '0));
endmodule

// File: tb/tb_softsw_reg.sv
module tb_softsw_reg;
  logic        clk = 1'b0;
  logic        rstN;
  logic        phi2;
  logic [15:0] addr;
  logic [7:0]  ctrlBits;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  softsw_reg dut (.clk(clk), .rstN(rstN), .phi2(phi2), .addr(addr),
                  .ctrlBits(ctrlBits));

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  exp;
    logic        inWin;
  } vec_t;

  // Expected outputs after each access, starting from all zero.
  localparam vec_t VECS [12] = '{
    '{16'hC081, 8'h01, 1'b1},  // idx0 set
    '{16'hC08F, 8'h81, 1'b1},  // idx7 set
    '{16'hC085, 8'h85, 1'b1},  // idx2 set
    '{16'hC080, 8'h84, 1'b1},  // idx0 clear
    '{16'hC09F, 8'h84, 1'b0},  // above the window
    '{16'hC07F, 8'h84, 1'b0},  // below the window
    '{16'hC08B, 8'hA4, 1'b1},  // idx5 set
    '{16'hC08E, 8'h24, 1'b1},  // idx7 clear
    '{16'h408F, 8'h24, 1'b0},  // only A15 differs
    '{16'hC08D, 8'h64, 1'b1},  // idx6 set
    '{16'hC084, 8'h60, 1'b1},  // idx2 clear
    '{16'hC083, 8'h62, 1'b1}   // idx1 set
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: ctrlBits=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling clock edge; returns at a falling edge with phi2 low.
  task automatic access(input logic [15:0] a, input int highClks);
    addr = a;
    phi2 = 1'b1;
    repeat (highClks) @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    addr = 16'h0000;
  endtask

  initial begin
    rstN = 1'b0;
    phi2 = 1'b0;
    addr = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(ctrlBits, 8'h00, "R6 reset state");

    for (int i = 0; i < 12; i++) begin
      access(VECS[i].a, 1 + (i % 3));
      if (VECS[i].inWin) check(ctrlBits, VECS[i].exp, "R3/R4/R5 table");
      else               check(ctrlBits, VECS[i].exp, "R1 outside window");
    end

    // R2: no change while phase 2 stays high, then one update on the fall
    addr = 16'hC087;
    phi2 = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrlBits, 8'h62, "R2 held during phase 2");
    phi2 = 1'b0;
    @(negedge clk);
    check(ctrlBits, 8'h6A, "R2 update after fall");

    // R8: early in-window address replaced by an outside one
    addr = 16'hC089;
    phi2 = 1'b1;
    repeat (2) @(negedge clk);
    addr = 16'h1234;
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    check(ctrlBits, 8'h6A, "R8 early glitch ignored");

    // R8: outside address early, in-window address last
    addr = 16'h0000;
    phi2 = 1'b1;
    @(negedge clk);
    addr = 16'hC089;
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    check(ctrlBits, 8'h7A, "R8 last address wins");

    // R9: long phase commits once; a second access then clears the bit
    access(16'hC088, 10);
    check(ctrlBits, 8'h6A, "R9 long phase");
    repeat (3) @(negedge clk);
    check(ctrlBits, 8'h6A, "R9 no repeat after phase");

    // R6: asynchronous clear between clock edges
    #2 rstN = 1'b0;
    #1 check(ctrlBits, 8'h00, "R6 async clear");
    @(negedge clk);

    // R7: access while reset is held
    access(16'hC081, 2);
    check(ctrlBits, 8'h00, "R7 access in reset");

    // R7: phase opened in reset, closed after release
    addr = 16'hC08F;
    phi2 = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    check(ctrlBits, 8'h00, "R7 phase across release");
    access(16'hC08F, 1);
    check(ctrlBits, 8'h80, "R7 normal after release");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: ran=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule